// File: doc/BRIEF.md
# Unaligned Bit-Field Copy Engine

This engine moves a run of bits from one byte-wide memory into another, where neither the starting bit in the source nor the starting bit in the destination needs to sit on a byte boundary. A caller gives a source bit position, a destination bit position and a bit count with a one-cycle `start` pulse. The engine then streams source bytes through a 16-bit accumulator and writes the destination one byte at a time. It answers with a one-cycle `done` pulse.

Destination bytes that are only partly covered by the run are handled by read-modify-write. Bits outside the copied range keep their old contents. Interior bytes, and every byte when both positions are byte aligned, are written whole and are not read back first. Both memories are read asynchronously: the data for an address is taken in the same cycle that the address is presented. The source and destination regions must not overlap.

The controller is a three-state machine:
- `ST_IDLE` waits for `start`. It moves to `ST_MOVE` when the count is non-zero, and straight to `ST_FINISH` when the count is zero.
- `ST_MOVE` does one memory access per cycle. When the accumulator holds fewer bits than the current destination byte needs, it reads a source byte. Otherwise it writes a destination byte. After the write that consumes the last bit it moves to `ST_FINISH`.
- `ST_FINISH` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `bitcopy_engine`

## Requirements
- R1: Bit positions are LSB-first: a bit position p names bit p%8 of byte p/8. Destination bit d+i ends up equal to source bit s+i for every i below the count.
- R2: A count of zero makes no memory access, and `done` pulses in the cycle after `start` is taken.
- R3: In the first destination byte, the bits below the destination bit index keep their previous value.
- R4: In the last destination byte, the bits above the final copied bit keep their previous value.
- R5: A destination byte that is fully covered is written without a destination read (`dst_rd` low). When both positions and the count are multiples of 8, the job makes no destination read at all.
- R6: `done` is high for exactly one cycle. It comes one cycle after the final destination write, and only once per job.
- R7: `start` is ignored while `busy` is high. The running job's result and its single `done` are unaffected.
- R8: Each cycle makes at most one memory access: a source read or a destination write (a write may carry its read-back).
- R9: Each source byte that overlaps the range is read exactly once, so the read count is ceil((s%8 + n)/8). The accumulator never holds more than 15 pending bits.
- R10: The destination write count is ceil((d%8 + n)/8), and counts up to 65535 bits are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Job request, taken only while idle |
| src_bit_pos | input | ADDR_W+3 | Source starting bit position |
| dst_bit_pos | input | ADDR_W+3 | Destination starting bit position |
| bit_count | input | CNT_W | Number of bits to copy |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| src_rd | output | 1 | Source read strobe |
| src_addr | output | ADDR_W | Source byte address |
| src_rdata | input | 8 | Source byte, valid in the same cycle as the address |
| dst_rd | output | 1 | Destination read-back strobe for a partial byte |
| dst_wr | output | 1 | Destination write strobe |
| dst_addr | output | ADDR_W | Destination byte address |
| dst_rdata | input | 8 | Old destination byte, valid in the same cycle |
| dst_wdata | output | 8 | Merged byte to write |

## Verification
The assertions check the following on every cycle:
- the idle engine stays off both memories;
- reads and writes never share a cycle;
- the accumulator stays within its capacity;
- `done` is a single pulse that follows the last write;
- a fully covered destination byte is never read back.

Only the bench scenarios can show the rest: that the copied bits land at the right positions, that the neighbouring bits at both ends survive, the exact read and write counts for each alignment, and that a `start` raised mid-job changes nothing.

// File: rtl/bitcopy_pkg.sv
package bitcopy_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MOVE   = 2'd1,
        ST_FINISH = 2'd2
    } bc_state_e;
endpackage

// File: rtl/bitcopy_accum.sv
// Pending-bit accumulator: appends source bytes above the held bits and
// retires consumed bits from the bottom.
module bitcopy_accum #(
    parameter int ACC_W  = 16,
    localparam int FILL_W = $clog2(ACC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [7:0]        load_byte,
    input  logic [2:0]        load_skip,
    input  logic              take,
    input  logic [3:0]        take_n,
    output logic [ACC_W-1:0]  acc,
    output logic [FILL_W-1:0] fill
);
    logic [ACC_W-1:0] incoming;

    always_comb begin
        incoming = ACC_W'(load_byte >> load_skip) << fill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            fill <= '0;
        end else if (clear) begin
            acc  <= '0;
            fill <= '0;
        end else if (load) begin
            acc  <= acc | incoming;
            fill <= fill + FILL_W'(8) - FILL_W'(load_skip);
        end else if (take) begin
            acc  <= acc >> take_n;
            fill <= fill - FILL_W'(take_n);
        end
    end

    // R9: capacity is never exceeded
    p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill < FILL_W'(ACC_W));
    // R8: loading and retiring never coincide
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && take));
endmodule

// File: rtl/bitcopy_merge.sv
// Combines new bits into an old destination byte under a field mask.
module bitcopy_merge (
    input  logic [7:0] old_byte,
    input  logic [7:0] new_bits,
    input  logic [2:0] lo_bit,
    input  logic [3:0] width,
    output logic [7:0] merged,
    output logic       partial
);
    logic [7:0] field;
    logic [7:0] mask;

    always_comb begin
        field   = (width >= 4'd8) ? 8'hFF : 8'((9'd1 << width) - 9'd1);
        mask    = field << lo_bit;
        merged  = (old_byte & ~mask) | ((new_bits << lo_bit) & mask);
        partial = (mask != 8'hFF);
    end
endmodule

// File: rtl/bitcopy_engine.sv
module bitcopy_engine
    import bitcopy_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 16,
    parameter int ACC_W  = 16,
    localparam int OFF_W  = ADDR_W + 3,
    localparam int FILL_W = $clog2(ACC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OFF_W-1:0]  src_bit_pos,
    input  logic [OFF_W-1:0]  dst_bit_pos,
    input  logic [CNT_W-1:0]  bit_count,
    output logic              busy,
    output logic              done,
    output logic              src_rd,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [7:0]        src_rdata,
    output logic              dst_rd,
    output logic              dst_wr,
    output logic [ADDR_W-1:0] dst_addr,
    input  logic [7:0]        dst_rdata,
    output logic [7:0]        dst_wdata
);
    bc_state_e         st, st_nx;
    logic [ADDR_W-1:0] src_ptr, dst_ptr;
    logic [2:0]        skip, dbit;
    logic [CNT_W-1:0]  remain;
    logic [3:0]        room, want;
    logic [ACC_W-1:0]  acc;
    logic [FILL_W-1:0] fill;
    logic              have_bits, partial, accept, last_wr;

    always_comb begin
        room      = 4'd8 - {1'b0, dbit};
        want      = (remain < CNT_W'(room)) ? remain[3:0] : room;
        have_bits = (fill >= FILL_W'(want));
        accept    = (st == ST_IDLE) && start;
    end

    bitcopy_accum #(.ACC_W(ACC_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .load      (src_rd),
        .load_byte (src_rdata),
        .load_skip (skip),
        .take      (dst_wr),
        .take_n    (want),
        .acc       (acc),
        .fill      (fill)
    );

    bitcopy_merge u_merge (
        .old_byte (dst_rdata),
        .new_bits (acc[7:0]),
        .lo_bit   (dbit),
        .width    (want),
        .merged   (dst_wdata),
        .partial  (partial)
    );

    // Outputs
    always_comb begin
        busy     = (st != ST_IDLE);
        done     = (st == ST_FINISH);
        src_rd   = (st == ST_MOVE) && !have_bits;
        dst_wr   = (st == ST_MOVE) && have_bits;
        dst_rd   = dst_wr && partial;
        src_addr = src_ptr;
        dst_addr = dst_ptr;
        last_wr  = dst_wr && (remain == CNT_W'(want));
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start) st_nx = (bit_count == '0) ? ST_FINISH : ST_MOVE;
            ST_MOVE:   if (last_wr) st_nx = ST_FINISH;
            ST_FINISH: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Job pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_ptr <= '0;
            dst_ptr <= '0;
            skip    <= '0;
            dbit    <= '0;
            remain  <= '0;
        end else if (accept) begin
            src_ptr <= src_bit_pos[OFF_W-1:3];
            skip    <= src_bit_pos[2:0];
            dst_ptr <= dst_bit_pos[OFF_W-1:3];
            dbit    <= dst_bit_pos[2:0];
            remain  <= bit_count;
        end else if (src_rd) begin
            src_ptr <= src_ptr + 1'b1;
            skip    <= '0;
        end else if (dst_wr) begin
            dst_ptr <= dst_ptr + 1'b1;
            dbit    <= '0;
            remain  <= remain - CNT_W'(want);
        end
    end

    // R2: an idle engine touches neither memory
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!src_rd && !dst_wr && !dst_rd));
    // R6: done lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: the final write is followed by done
    p_last_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_wr && remain == CNT_W'(want)) |=> done);
    // R5: a fully covered byte is never read back
    p_full_blind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_wr && dbit == 3'd0 && want == 4'd8) |-> !dst_rd);
    // R8: one access per cycle
    p_one_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_rd && dst_wr));
endmodule

// File: tb/bitcopy_engine_test.sv
module bitcopy_engine_test;
    localparam int ADDR_W = 13;
    localparam int CNT_W  = 16;
    localparam int OFF_W  = ADDR_W + 3;
    localparam int MEM_N  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [OFF_W-1:0]  src_bit_pos = '0;
    logic [OFF_W-1:0]  dst_bit_pos = '0;
    logic [CNT_W-1:0]  bit_count = '0;
    logic              busy, done, src_rd, dst_rd, dst_wr;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [7:0]        src_rdata, dst_rdata, dst_wdata;

    logic [7:0] smem [0:MEM_N-1];
    logic [7:0] dmem [0:MEM_N-1];
    logic [7:0] expm [0:MEM_N-1];

    typedef struct {
        int         addr;
        logic [7:0] val;
        string      req;
    } item_t;
    item_t sb[$];

    int compared = 0, mismatched = 0;
    int cyc = 0, rd_cnt = 0, wr_cnt = 0, drd_cnt = 0, done_cnt = 0;
    int last_wr_cyc = 0, done_cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign src_rdata = smem[src_addr];
    assign dst_rdata = dmem[dst_addr];
    always @(posedge clk) if (dst_wr) dmem[dst_addr] <= dst_wdata;

    bitcopy_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_bit_pos(src_bit_pos), .dst_bit_pos(dst_bit_pos), .bit_count(bit_count),
        .busy(busy), .done(done),
        .src_rd(src_rd), .src_addr(src_addr), .src_rdata(src_rdata),
        .dst_rd(dst_rd), .dst_wr(dst_wr), .dst_addr(dst_addr),
        .dst_rdata(dst_rdata), .dst_wdata(dst_wdata)
    );

    // Activity monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (src_rd) rd_cnt <= rd_cnt + 1;
        if (dst_wr) begin
            wr_cnt      <= wr_cnt + 1;
            last_wr_cyc <= cyc;
        end
        if (dst_rd) drd_cnt <= drd_cnt + 1;
        if (done) begin
            done_cnt <= done_cnt + 1;
            done_cyc <= cyc;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill_dst(int seed);
        for (int i = 0; i < MEM_N; i++) dmem[i] = 8'(i * 91 + seed);
    endtask

    // Scoreboard monitor: pops expected bytes and compares with memory
    task automatic drain_scoreboard();
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(dmem[it.addr] == it.val, it.req,
                  $sformatf("dst byte %0d", it.addr), dmem[it.addr], it.val);
        end
    endtask

    task automatic run_job(int so, int dpos, int n, bit poke_busy, int seed);
        int lo, hi, first, last;
        fill_dst(seed);
        for (int i = 0; i < MEM_N; i++) expm[i] = dmem[i];
        for (int i = 0; i < n; i++) begin
            int sbit = so + i;
            int dbt  = dpos + i;
            expm[dbt >> 3][dbt & 7] = smem[sbit >> 3][sbit & 7];
        end
        first = dpos / 8;
        last  = (n > 0) ? (dpos + n - 1) / 8 : first;
        lo = (first > 0) ? first - 1 : 0;
        hi = (last < MEM_N - 1) ? last + 1 : MEM_N - 1;
        for (int a = lo; a <= hi; a++) begin
            item_t it;
            it.addr = a;
            it.val  = expm[a];
            it.req  = (a <= first) ? "R3" : ((a >= last) ? "R4" : "R1");
            sb.push_back(it);
        end
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; drd_cnt = 0; done_cnt = 0;
        start = 1'b1;
        src_bit_pos = OFF_W'(so);
        dst_bit_pos = OFF_W'(dpos);
        bit_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            src_bit_pos = '0;
            dst_bit_pos = OFF_W'(dpos);
            bit_count = 16'd8;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        drain_scoreboard();
        check(done_cnt == 1, "R6", "done pulse count", done_cnt, 1);
        if (poke_busy) check(done_cnt == 1, "R7", "done count with mid-job start", done_cnt, 1);
        if (n == 0) begin
            check(rd_cnt == 0 && wr_cnt == 0, "R2", "accesses for zero count", rd_cnt + wr_cnt, 0);
        end else begin
            check(done_cyc == last_wr_cyc + 1, "R6", "done after last write",
                  done_cyc - last_wr_cyc, 1);
            check(rd_cnt == ((so % 8) + n + 7) / 8, "R9", "source reads",
                  rd_cnt, ((so % 8) + n + 7) / 8);
            check(wr_cnt == ((dpos % 8) + n + 7) / 8, "R10", "destination writes",
                  wr_cnt, ((dpos % 8) + n + 7) / 8);
        end
        if (dpos % 8 == 0 && n % 8 == 0)
            check(drd_cnt == 0, "R5", "destination reads on aligned job", drd_cnt, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) smem[i] = 8'((i * 37 + 11) ^ (i >> 3));
        fill_dst(5);
        repeat (3) @(negedge clk);
        check(!busy && !done && !src_rd && !dst_wr, "R2", "reset outputs quiet",
              {busy, done, src_rd, dst_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_job(0, 0, 64, 1'b0, 3);        // R5 aligned, whole bytes
        run_job(3, 5, 20, 1'b0, 7);        // R1 R3 R4 both unaligned
        run_job(7, 2, 3, 1'b0, 9);         // R3 R4 inside one byte
        run_job(12, 0, 1, 1'b0, 13);       // R1 single bit
        run_job(9, 17, 0, 1'b0, 17);       // R2 zero count
        run_job(5, 13, 200, 1'b1, 21);     // R7 start while busy
        run_job(16, 24, 13, 1'b0, 29);     // R4 aligned start, partial end
        run_job(1, 0, 65535, 1'b0, 33);    // R10 largest count
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule